// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block moves a programmed number of bytes between system memory and a card-side byte stream. Software prepares a chain of 16-byte descriptors in memory, each giving a status word, a buffer length, a buffer address and a pointer to the next descriptor. A start pulse then hands the engine a base pointer, a direction, a byte count and a block size. The engine fetches descriptors one after another and streams each buffer. It writes the status word back with the ownership bit released. When the walk ends it raises a set of sticky completion flags.

Memory is reached through a simple word master: a request is held with a stable address until ready is returned. Data crosses to the card one byte per handshake, taken from each memory word in little-endian lane order. A programmable wait limit protects against a memory that never answers. When it expires, the descriptor in flight is written back with its error bit set and the transfer ends.

Top module: `sdma_chain_engine`

## Requirements
- R1: A start pulse is ignored while the enable input is low, the byte count is 0 or the block size is 0. In that case busy stays low, no memory request is made and the flags keep their values.
- R2: A descriptor is read as four 32-bit words at its address plus 0, 4, 8 and 12, in that order: status, size, buffer address, next pointer. Each request holds its address and direction until ready is seen.
- R3: A size of 0 is taken as MAX_DESC, and a size above MAX_DESC is cut to MAX_DESC. The bytes moved for a descriptor are the smaller of that value and the remaining count.
- R4: Bits 1:0 of the buffer address are ignored. Data always starts at the word containing that address, at lane 0.
- R5: In transmit (direction input 1), each memory word is sent lane 0 first (bits 7:0) through lane 3 (bits 31:24). The byte is held stable while the card withholds ready.
- R6: In receive (direction input 0), card bytes fill lanes 0 to 3 of successive words, which are written to the buffer. A final partial word has zeros in its unused lanes.
- R7: After its data moves, each descriptor's status word is written back to the descriptor address. Bit 31 (owner) is cleared and the other bits are kept.
- R8: The walk follows the next pointer. It stops after a descriptor whose status bit 2 (last) is set, or once the remaining count reaches 0. Later descriptors are not touched.
- R9: On completion, flag_data_done, flag_aux and dma_sum are set, together with dma_tx for transmit or dma_rx for receive. All flags are cleared when the next start is accepted.
- R10: A receive start waits without any memory access until the card-ready input is high.
- R11: A memory request that waits more than wait_lim_i cycles aborts the transfer. The current descriptor is written back with bit 30 (error) set and bit 31 cleared. The completion flags are then raised.
- R12: rem_o holds the remaining byte count. It drops by the bytes moved at each descriptor write-back and never increases while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| dir_tx_i | input | 1 | 1 = memory to card, 0 = card to memory |
| dma_en_i | input | 1 | Engine enable |
| byte_cnt_i | input | CNT_W | Bytes to move |
| blk_size_i | input | BS_W | Block size, must be non-zero |
| desc_base_i | input | AW | First descriptor address |
| card_rdy_i | input | 1 | Card has data ready (receive) |
| wait_lim_i | input | LIM_W | Memory wait limit in cycles |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ready_i | input | 1 | Memory access done |
| tx_valid_o | output | 1 | Byte to card valid |
| tx_data_o | output | 8 | Byte to card |
| tx_ready_i | input | 1 | Card accepts byte |
| rx_valid_i | input | 1 | Byte from card valid |
| rx_data_i | input | 8 | Byte from card |
| rx_ready_o | output | 1 | Engine accepts byte |
| busy_o | output | 1 | Transfer in progress |
| rem_o | output | CNT_W | Remaining byte count |
| flag_data_done_o | output | 1 | Data complete flag |
| flag_aux_o | output | 1 | Auxiliary completion flag |
| dma_sum_o | output | 1 | DMA summary flag |
| dma_tx_o | output | 1 | Transmit done flag |
| dma_rx_o | output | 1 | Receive done flag |

## Verification
An accepted start raises busy at the next edge, after the two-stage reset release has passed. The first descriptor request appears in that same cycle. Each memory or card handshake takes effect at the rising edge where both sides agree. The flags, rem_o and the fall of busy all update at the edge that completes the final status write-back. The bench drives and samples only on falling edges. It decides each handshake there and checks the byte that will be taken at the following rising edge. Flags, remaining count and the whole memory image are compared only after busy has been seen low.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_RDY, S_FETCH, S_TX_RD, S_TX_SEND, S_RX_RECV, S_RX_WR, S_WBACK
  } sdma_state_e;

  localparam int ST_OWN_BIT  = 31;
  localparam int ST_ERR_BIT  = 30;
  localparam int ST_LAST_BIT = 2;
endpackage

// File: rtl/sdma_len_calc.sv
module sdma_len_calc #(
  parameter int CNT_W    = 24,
  parameter int MAX_DESC = 8192
) (
  input  logic [31:0]      size_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [31:0] MAXV = 32'(MAX_DESC);
  logic [31:0] clamped, rem_ext;

  always_comb begin
    rem_ext = 32'(rem_i);
    if (size_i == 32'd0 || size_i > MAXV) clamped = MAXV;
    else                                  clamped = size_i;
    if (clamped < rem_ext) len_o = clamped[CNT_W-1:0];
    else                   len_o = rem_i;
  end
endmodule

// File: rtl/sdma_watchdog.sv
module sdma_watchdog #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             expire_o
);
  logic [LIM_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!wait_i)            cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = wait_i && (cnt_q >= lim_i);

  assert_expire_needs_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && !expire_o) |=> (cnt_q != '0) || !wait_i);
endmodule

// File: rtl/sdma_byte_lane.sv
module sdma_byte_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        step_i,
  input  logic        push_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o,
  output logic [7:0]  byte_o,
  output logic [1:0]  idx_o
);
  logic [31:0] word_q, word_d;
  logic [1:0]  idx_q, idx_d;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    if (clr_i) begin
      word_d = '0;
      idx_d  = '0;
    end else if (load_i) begin
      word_d = word_i;
      idx_d  = '0;
    end else if (push_i) begin
      word_d[{idx_q, 3'b000} +: 8] = byte_i;
      idx_d = idx_q + 2'd1;
    end else if (step_i) begin
      idx_d = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
    end
  end

  assign word_o = word_q;
  assign idx_o  = idx_q;
  assign byte_o = word_q[{idx_q, 3'b000} +: 8];

  assert_load_restarts_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (idx_o == 2'd0) && (byte_o == $past(word_i[7:0])));
endmodule

// File: rtl/sdma_chain_engine.sv
module sdma_chain_engine
  import sdma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CNT_W    = 24,
  parameter int BS_W     = 16,
  parameter int LIM_W    = 16,
  parameter int MAX_DESC = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_tx_i,
  input  logic             dma_en_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [BS_W-1:0]  blk_size_i,
  input  logic [AW-1:0]    desc_base_i,
  input  logic             card_rdy_i,
  input  logic [LIM_W-1:0] wait_lim_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             rx_ready_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             flag_data_done_o,
  output logic             flag_aux_o,
  output logic             dma_sum_o,
  output logic             dma_tx_o,
  output logic             dma_rx_o
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_DESC);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_s  <= rst_s1_q;
    end
  end

  sdma_state_e state_q, state_d;
  logic             dir_q, dir_d, err_q, err_d;
  logic [CNT_W-1:0] rem_q, rem_d, len_q, len_d, mv_q, mv_d, rem_left, len_w;
  logic [AW-1:0]    dsc_q, dsc_d, wad_q, wad_d;
  logic [1:0]       fi_q, fi_d;
  logic [31:0]      st_q, st_d, sz_q, sz_d, ba_q, ba_d, nx_q, nx_d;
  logic [4:0]       flg_q, flg_d;   // {data_done, aux, sum, tx, rx}

  logic lane_clr, lane_load, lane_step, lane_push;
  logic [31:0] lane_word;
  logic [7:0]  lane_byte;
  logic [1:0]  lane_idx;
  logic acc_done, tmo, go_ok, wb_last;

  sdma_len_calc #(.CNT_W(CNT_W), .MAX_DESC(MAX_DESC)) len_i (
    .size_i(sz_q), .rem_i(rem_q), .len_o(len_w));

  sdma_watchdog #(.LIM_W(LIM_W)) wdog_i (
    .clk(clk), .rst_n(rst_n_s), .wait_i(mem_req_o && !mem_ready_i),
    .lim_i(wait_lim_i), .expire_o(tmo));

  sdma_byte_lane lane_i (
    .clk(clk), .rst_n(rst_n_s), .clr_i(lane_clr), .load_i(lane_load),
    .word_i(mem_rdata_i), .step_i(lane_step), .push_i(lane_push),
    .byte_i(rx_data_i), .word_o(lane_word), .byte_o(lane_byte), .idx_o(lane_idx));

  // memory and card port drive
  always_comb begin
    mem_req_o   = (state_q == S_FETCH) || (state_q == S_TX_RD) ||
                  (state_q == S_RX_WR) || (state_q == S_WBACK);
    mem_we_o    = (state_q == S_RX_WR) || (state_q == S_WBACK);
    mem_addr_o  = wad_q;
    mem_wdata_o = lane_word;
    if (state_q == S_FETCH) mem_addr_o = dsc_q + AW'({fi_q, 2'b00});
    if (state_q == S_WBACK) begin
      mem_addr_o  = dsc_q;
      mem_wdata_o = st_q;
      mem_wdata_o[ST_OWN_BIT] = 1'b0;
      if (err_q) mem_wdata_o[ST_ERR_BIT] = 1'b1;
    end
  end

  assign acc_done   = mem_req_o && mem_ready_i;
  assign tx_valid_o = (state_q == S_TX_SEND);
  assign tx_data_o  = lane_byte;
  assign rx_ready_o = (state_q == S_RX_RECV);
  assign busy_o     = (state_q != S_IDLE);
  assign rem_o      = rem_q;
  assign {flag_data_done_o, flag_aux_o, dma_sum_o, dma_tx_o, dma_rx_o} = flg_q;
  assign go_ok      = dma_en_i && (byte_cnt_i != '0) && (blk_size_i != '0);
  assign rem_left   = rem_q - mv_q;
  assign wb_last    = err_q || tmo || st_q[ST_LAST_BIT] || (rem_left == '0);

  // next-state
  always_comb begin
    state_d = state_q; dir_d = dir_q; rem_d = rem_q; dsc_d = dsc_q;
    fi_d = fi_q; st_d = st_q; sz_d = sz_q; ba_d = ba_q; nx_d = nx_q;
    len_d = len_q; mv_d = mv_q; wad_d = wad_q; err_d = err_q; flg_d = flg_q;
    lane_clr = 1'b0; lane_load = 1'b0; lane_step = 1'b0; lane_push = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i && go_ok) begin
        rem_d = byte_cnt_i; dsc_d = desc_base_i; dir_d = dir_tx_i;
        err_d = 1'b0; flg_d = '0; fi_d = '0; st_d = '0; mv_d = '0;
        state_d = (dir_tx_i || card_rdy_i) ? S_FETCH : S_WAIT_RDY;
      end
      S_WAIT_RDY: if (card_rdy_i) state_d = S_FETCH;
      S_FETCH: begin
        if (tmo) begin
          err_d = 1'b1; state_d = S_WBACK;
        end else if (acc_done) begin
          unique case (fi_q)
            2'd0: st_d = mem_rdata_i;
            2'd1: sz_d = mem_rdata_i;
            2'd2: ba_d = mem_rdata_i;
            default: nx_d = mem_rdata_i;
          endcase
          fi_d = fi_q + 2'd1;
          if (fi_q == 2'd3) begin
            len_d = len_w; mv_d = '0; lane_clr = 1'b1;
            wad_d = {ba_q[AW-1:2], 2'b00};
            state_d = dir_q ? S_TX_RD : S_RX_RECV;
          end
        end
      end
      S_TX_RD: begin
        if (tmo) begin
          err_d = 1'b1; state_d = S_WBACK;
        end else if (acc_done) begin
          lane_load = 1'b1; wad_d = wad_q + AW'(4); state_d = S_TX_SEND;
        end
      end
      S_TX_SEND: if (tx_ready_i) begin
        lane_step = 1'b1; mv_d = mv_q + 1'b1;
        if (mv_q + 1'b1 == len_q)  state_d = S_WBACK;
        else if (lane_idx == 2'd3) state_d = S_TX_RD;
      end
      S_RX_RECV: if (rx_valid_i) begin
        lane_push = 1'b1; mv_d = mv_q + 1'b1;
        if ((mv_q + 1'b1 == len_q) || (lane_idx == 2'd3)) state_d = S_RX_WR;
      end
      S_RX_WR: begin
        if (tmo) begin
          err_d = 1'b1; state_d = S_WBACK;
        end else if (acc_done) begin
          lane_clr = 1'b1; wad_d = wad_q + AW'(4);
          state_d = (mv_q == len_q) ? S_WBACK : S_RX_RECV;
        end
      end
      default: begin // S_WBACK
        if (acc_done || tmo) begin
          rem_d = rem_left;
          if (wb_last) begin
            flg_d = {3'b111, dir_q, !dir_q}; state_d = S_IDLE;
          end else begin
            dsc_d = nx_q[AW-1:0]; fi_d = '0; st_d = '0; mv_d = '0;
            state_d = S_FETCH;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE; dir_q <= 1'b0; rem_q <= '0; dsc_q <= '0; fi_q <= '0;
      st_q <= '0; sz_q <= '0; ba_q <= '0; nx_q <= '0; len_q <= '0; mv_q <= '0;
      wad_q <= '0; err_q <= 1'b0; flg_q <= '0;
    end else begin
      state_q <= state_d; dir_q <= dir_d; rem_q <= rem_d; dsc_q <= dsc_d; fi_q <= fi_d;
      st_q <= st_d; sz_q <= sz_d; ba_q <= ba_d; nx_q <= nx_d; len_q <= len_d; mv_q <= mv_d;
      wad_q <= wad_d; err_q <= err_d; flg_q <= flg_d;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o |-> (!mem_req_o && !tx_valid_o && !rx_ready_o));
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_o && !mem_ready_i && !tmo) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_len_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_valid_o || rx_ready_o) |-> (len_q != '0) && (len_q <= MAXC) && (mv_q < len_q));
  assert_tx_held_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_owner_released_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we_o && state_q == S_WBACK) |-> !mem_wdata_o[ST_OWN_BIT]);
  assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(dma_sum_o) |-> (dma_tx_o != dma_rx_o));
  assert_wait_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && !card_rdy_i && !$past(busy_o)) |-> (dir_q || mem_req_o == (state_q == S_FETCH)));
  assert_rem_monotonic_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && $past(busy_o)) |-> (rem_o <= $past(rem_o)));
endmodule

// File: tb/sdma_chain_engine_tb.sv
module sdma_chain_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD       = 64;
  localparam int CNT_W      = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, dir_tx_i = 0, dma_en_i = 0, card_rdy_i = 1;
  logic [CNT_W-1:0] byte_cnt_i = '0;
  logic [15:0] blk_size_i = '0, wait_lim_i = 16'd16;
  logic [31:0] desc_base_i = '0;
  logic mem_req_o, mem_we_o, mem_ready_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic tx_valid_o, tx_ready_i = 0, rx_valid_i = 0, rx_ready_o;
  logic [7:0] tx_data_o, rx_data_i = '0;
  logic busy_o, fdd, faux, fsum, ftx, frx;
  logic [CNT_W-1:0] rem_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_chain_engine #(.AW(32), .CNT_W(CNT_W), .BS_W(16), .LIM_W(16), .MAX_DESC(MAXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_tx_i(dir_tx_i), .dma_en_i(dma_en_i),
    .byte_cnt_i(byte_cnt_i), .blk_size_i(blk_size_i), .desc_base_i(desc_base_i),
    .card_rdy_i(card_rdy_i), .wait_lim_i(wait_lim_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .busy_o(busy_o), .rem_o(rem_o),
    .flag_data_done_o(fdd), .flag_aux_o(faux), .dma_sum_o(fsum), .dma_tx_o(ftx), .dma_rx_o(frx));

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_m [0:1023];
  logic [7:0] exp_tx[$];
  logic [7:0] rx_q[$];
  int exp_rem;
  int waitc = 0, lat = 0;
  bit pend = 0, pend_we = 0, rx_pend = 0;
  logic [9:0] pend_idx;
  logic [31:0] pend_data;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory, card sink and card source models: all decisions at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      if (pend_we) mem[pend_idx] = pend_data;
      waitc = 0; lat = (lat + 1) % 4; pend = 0;
    end
    mem_ready_i = 0;
    if (mem_req_o && !mem_addr_o[31]) begin
      if (waitc >= lat) begin
        mem_ready_i = 1; mem_rdata_i = mem[mem_addr_o[11:2]];
        pend = 1; pend_we = mem_we_o; pend_idx = mem_addr_o[11:2]; pend_data = mem_wdata_o;
      end else waitc++;
    end else if (mem_req_o) waitc++;
    tx_ready_i = (cyc % 3) != 1;
    if (tx_valid_o && tx_ready_i) begin
      if (exp_tx.size() == 0) chk(0, "R5 extra byte", tx_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        chk(tx_data_o == e, "R5 tx byte", tx_data_o, e);
      end
    end
    if (rx_pend) void'(rx_q.pop_front());
    rx_valid_i = ((cyc % 4) != 2) && (rx_q.size() > 0);
    rx_data_i  = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
    rx_pend    = rx_valid_i && rx_ready_o;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    chk(0, "watchdog", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // behavioural expectation of a whole walk
  task automatic model_run(input logic [31:0] base, input int cnt, input bit tx);
    int rem = cnt, rxi = 0, szc, n;
    logic [31:0] d = base, st, sz, ba, nx, a;
    forever begin
      st = exp_m[d[11:2]]; sz = exp_m[d[11:2]+1]; ba = exp_m[d[11:2]+2]; nx = exp_m[d[11:2]+3];
      szc = (sz == 0 || sz > 32'(MAXD)) ? MAXD : int'(sz);
      n = (szc < rem) ? szc : rem;
      if (ba[31]) begin
        exp_m[d[11:2]] = (st & 32'h7FFF_FFFF) | 32'h4000_0000;
        break;
      end
      for (int i = 0; i < n; i++) begin
        a = (ba & 32'hFFFF_FFFC) + 32'(i);
        if (tx) exp_tx.push_back(exp_m[a[11:2]][a[1:0]*8 +: 8]);
        else begin
          exp_m[a[11:2]][a[1:0]*8 +: 8] = rx_q[rxi]; rxi++;
        end
      end
      if (!tx && (n % 4) != 0) begin
        a = (ba & 32'hFFFF_FFFC) + 32'(n - 1);
        for (int l = 0; l < 4; l++) if (l > int'(a[1:0])) exp_m[a[11:2]][l*8 +: 8] = 8'h00;
      end
      exp_m[d[11:2]] = st & 32'h7FFF_FFFF;
      rem -= n;
      if (st[2] || rem == 0) break;
      d = nx;
    end
    exp_rem = rem;
  endtask

  task automatic set_desc(input int at, input logic [31:0] st, sz, ba, nx);
    mem[at/4] = st; mem[at/4+1] = sz; mem[at/4+2] = ba; mem[at/4+3] = nx;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) mem[i] = {8'(i*4+3), 8'(i*4+2), 8'(i*4+1), 8'(i*4)} ^ 32'h5A00_0000;
  endtask

  task automatic pulse_start(input logic [31:0] base, input int cnt, input bit tx, input bit en,
                             input int blk);
    desc_base_i = base; byte_cnt_i = CNT_W'(cnt); dir_tx_i = tx; dma_en_i = en;
    blk_size_i = 16'(blk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic run_and_check(input string req, input logic [31:0] base, input int cnt,
                               input bit tx);
    int mism = 0, first = -1;
    for (int i = 0; i < 1024; i++) exp_m[i] = mem[i];
    model_run(base, cnt, tx);
    pulse_start(base, cnt, tx, 1, 512);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_m[i]) begin
      mism++; if (first < 0) first = i;
    end
    chk(mism == 0, {req, " memory image"}, (first < 0) ? 0 : mem[first], (first < 0) ? 0 : exp_m[first]);
    chk(exp_tx.size() == 0, {req, " bytes left unsent"}, exp_tx.size(), 0);
    chk({fdd, faux, fsum, ftx, frx} == {3'b111, tx, !tx}, "R9 flags",
        {fdd, faux, fsum, ftx, frx}, {3'b111, tx, !tx});
    chk(int'(rem_o) == exp_rem, "R12 remaining", rem_o, exp_rem);
  endtask

  initial begin
    fill_mem();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state
    chk(!busy_o && !mem_req_o && !tx_valid_o && !rx_ready_o, "reset idle", busy_o, 0);
    chk({fdd, faux, fsum, ftx, frx} == 5'b0 && rem_o == 0, "reset flags", {fdd, faux, fsum, ftx, frx}, 0);

    // R1 ignored starts
    set_desc(32'h100, 32'h8000_000C, 32'd10, 32'h201, 32'h0);
    for (int k = 0; k < 3; k++) begin
      bit saw = 0;
      pulse_start(32'h100, (k == 1) ? 0 : 10, 1, (k != 0), (k == 2) ? 0 : 512);
      for (int c = 0; c < 8; c++) begin
        if (busy_o || mem_req_o) saw = 1;
        @(negedge clk);
      end
      chk(!saw && {fdd, fsum} == 2'b0, "R1 start ignored", saw, 0);
    end

    // R2 R4 R5 R7 single transmit, unaligned buffer address
    run_and_check("R4 single tx", 32'h100, 10, 1);

    // R3 R8 chain: size 5, size 0 -> max, size 300 -> max cut by count; stop on count
    set_desc(32'h140, 32'h8000_0018, 32'd5,   32'h400, 32'h160);
    set_desc(32'h160, 32'h8000_0010, 32'd0,   32'h500, 32'h180);
    set_desc(32'h180, 32'h8000_0010, 32'd300, 32'h600, 32'h1A0);
    set_desc(32'h1A0, 32'h8000_0014, 32'd8,   32'h700, 32'h0);
    run_and_check("R3 R8 chain tx", 32'h140, 100, 1);
    chk(mem[32'h1A0/4] == 32'h8000_0014, "R8 untouched descriptor", mem[32'h1A0/4], 32'h8000_0014);

    // R8 R12 stop on last bit with count left
    set_desc(32'h1C0, 32'h8000_000C, 32'd8, 32'h800, 32'h1E0);
    set_desc(32'h1E0, 32'h8000_0010, 32'd8, 32'h840, 32'h0);
    run_and_check("R8 last bit", 32'h1C0, 50, 1);
    chk(rem_o == 42, "R12 remaining after last", rem_o, 42);

    // R10 receive waits for card ready, then R6 packing
    set_desc(32'h200, 32'h8000_0018, 32'd6, 32'h300, 32'h220);
    set_desc(32'h220, 32'h8000_0014, 32'd7, 32'h322, 32'h0);
    for (int i = 0; i < 13; i++) rx_q.push_back(8'(8'hC0 + i));
    card_rdy_i = 0;
    for (int i = 0; i < 1024; i++) exp_m[i] = mem[i];
    model_run(32'h200, 13, 0);
    pulse_start(32'h200, 13, 0, 1, 512);
    begin
      bit saw = 0;
      for (int c = 0; c < 10; c++) begin
        if (mem_req_o) saw = 1;
        @(negedge clk);
      end
      chk(!saw && busy_o, "R10 wait for card", saw, 0);
    end
    card_rdy_i = 1;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(mem[32'h304/4] == exp_m[32'h304/4], "R6 partial word zero lanes", mem[32'h304/4], exp_m[32'h304/4]);
    chk(mem[32'h320/4] == exp_m[32'h320/4], "R6 second buffer", mem[32'h320/4], exp_m[32'h320/4]);
    chk(mem[32'h200/4] == 32'h0000_0018, "R7 rx status", mem[32'h200/4], 32'h18);
    chk({fdd, faux, fsum, ftx, frx} == 5'b11101, "R9 rx flags", {fdd, faux, fsum, ftx, frx}, 5'b11101);
    chk(rem_o == 0, "R12 rx remaining", rem_o, 0);

    // R11 memory stall aborts, error bit written back
    set_desc(32'h240, 32'h8000_0008, 32'd4, 32'h900, 32'h260);
    set_desc(32'h260, 32'h8000_0004, 32'd8, 32'h8000_0000, 32'h0);
    run_and_check("R11 stall", 32'h240, 20, 1);
    chk(mem[32'h260/4] == 32'h4000_0004, "R11 error status", mem[32'h260/4], 32'h4000_0004);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule